// File: doc/BRIEF.md
# Grouped Interrupt Combiner Controller

This block collects a large set of level-sensitive interrupt lines and reduces them to one request per group of eight, so that a parent interrupt controller only sees a handful of lines. Each input can be enabled on its own. A group request is high while any enabled input of that group is high. The request drops one cycle after the last such input goes low or is disabled.

Software reaches the enables and the per-input status through a simple single-cycle register bus. Four groups share each 32-bit register bank, one byte lane per group. Banks sit 0x10 bytes apart. Each bank has a set port and a clear port for its enables, so software can change one input without a read-modify-write. The number of groups is a parameter. Registers and inputs that do not exist read as zero and ignore writes.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit and every group request is 0, so a read of any enable register returns 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1 and leaves the others unchanged. The new value is readable at offset 0x0 from the next cycle.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R4: Reading offset 0xC of bank k returns, for each bit, input AND enable. Bank k starts at address k*0x10. Group g lies in bank g/4 at bits (g mod 4)*8 to (g mod 4)*8+7. Input g*8+b is bit b of group g.
- R5: Output grp_req[g] equals the OR of the eight status bits of group g as they stood at the previous clock edge, so an input or enable change reaches the output one cycle later.
- R6: The request is level-sensitive. It stays high for as long as an enabled input of its group stays high, and it falls one cycle after that input drops or is disabled.
- R7: Reads return 0 at offset 0x4, at every low-nibble offset other than 0x0 and 0xC, and in any bank at or beyond ceil(NUM_GROUPS/4).
- R8: Writes to offset 0xC, to unused offsets or to out-of-range banks leave every enable bit unchanged. Enable bits of groups beyond NUM_GROUPS in a partly filled bank stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt inputs |
| grp_req | output | NUM_GROUPS | Registered combined request per group |

## Verification
The checker tests on every cycle that an accepted set write leaves its bits at 1 and an accepted clear write leaves its bits at 0. It also checks that writes to ignored targets leave the enable state stable, that unused read addresses return zero, and that all requests are low one cycle after the enabled status is all zero. The exact group-to-lane mapping, the one-cycle request latency for each group and the status read values can only be shown by the bench's scenarios. In those scenarios a reference model of the enables and inputs predicts every request vector and every read word under random traffic, and also under directed hold, drop and out-of-range cases.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int BANK_W = LANE_W * LANES;
    localparam int OFS_W  = 4;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     in_range;
    } access_t;

    function automatic reg_sel_e offset_to_sel(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            4'h0:    s = REG_EN_SET;
            4'h4:    s = REG_EN_CLR;
            4'hC:    s = REG_STATUS;
            default: s = REG_NONE;
        endcase
        return s;
    endfunction

    function automatic int num_banks(input int ngroups);
        return (ngroups + LANES - 1) / LANES;
    endfunction

    function automatic logic [BANK_W-1:0] lane_mask(input int bank, input int ngroups);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            if (bank * LANES + l < ngroups) m[l*LANE_W +: LANE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cmb_addr_decode.sv
module cmb_addr_decode
    import cmb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 5,
    localparam int BIDX_W   = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BIDX_W-1:0] bank_idx,
    output access_t           acc
);

    assign bank_idx = addr[ADDR_W-1:OFS_W];

    always_comb begin
        acc.sel      = offset_to_sel(addr[OFS_W-1:0]);
        acc.in_range = (int'(bank_idx) < NUM_BANKS);
    end

endmodule

// File: rtl/cmb_bank.sv
module cmb_bank
    import cmb_pkg::*;
#(
    parameter int BANK_ID    = 0,
    parameter int NUM_GROUPS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] irq_lanes,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] stat
);

    localparam logic [BANK_W-1:0] LMASK = lane_mask(BANK_ID, NUM_GROUPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_set) begin
            en_q <= (en_q | wdata) & LMASK;
        end else if (wr_clr) begin
            en_q <= en_q & ~wdata;
        end
    end

    assign stat = irq_lanes & en_q;

endmodule

// File: rtl/cmb_req_reg.sv
module cmb_req_reg
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_GROUPS*LANE_W-1:0] stat_in,
    output logic [NUM_GROUPS-1:0]        grp_req
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) grp_req[g] <= 1'b0;
            else     grp_req[g] <= |stat_in[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [BANK_W-1:0]            bus_wdata,
    output logic [BANK_W-1:0]            bus_rdata,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_in,
    output logic [NUM_GROUPS-1:0]        grp_req
);

    localparam int NUM_BANKS = num_banks(NUM_GROUPS);
    localparam int BIDX_W    = ADDR_W - OFS_W;
    localparam int FLAT_W    = NUM_BANKS * BANK_W;
    localparam int IN_W      = NUM_GROUPS * LANE_W;

    logic [BIDX_W-1:0] bank_idx;
    access_t           acc;
    logic [FLAT_W-1:0] irq_pad;
    logic [FLAT_W-1:0] en_flat;
    logic [FLAT_W-1:0] stat_flat;
    logic [BANK_W-1:0] en_arr   [NUM_BANKS];
    logic [BANK_W-1:0] stat_arr [NUM_BANKS];

    assign irq_pad = FLAT_W'(irq_in);

    cmb_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .addr     (bus_addr),
        .bank_idx (bank_idx),
        .acc      (acc)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = bus_we && acc.in_range && (int'(bank_idx) == b);

        cmb_bank #(
            .BANK_ID    (b),
            .NUM_GROUPS (NUM_GROUPS)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_set    (hit && (acc.sel == REG_EN_SET)),
            .wr_clr    (hit && (acc.sel == REG_EN_CLR)),
            .wdata     (bus_wdata),
            .irq_lanes (irq_pad[b*BANK_W +: BANK_W]),
            .en_q      (en_arr[b]),
            .stat      (stat_arr[b])
        );

        assign en_flat[b*BANK_W +: BANK_W]   = en_arr[b];
        assign stat_flat[b*BANK_W +: BANK_W] = stat_arr[b];
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc.in_range && (int'(bank_idx) == b)) begin
                case (acc.sel)
                    REG_EN_SET: bus_rdata = en_arr[b];
                    REG_STATUS: bus_rdata = stat_arr[b];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    cmb_req_reg #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_req (
        .clk     (clk),
        .rst     (rst),
        .stat_in (stat_flat[IN_W-1:0]),
        .grp_req (grp_req)
    );

endmodule

// File: rtl/cmb_checker.sv
module cmb_checker
    import cmb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 12,
    localparam int NUM_BANKS = num_banks(NUM_GROUPS),
    localparam int FLAT_W    = NUM_BANKS * BANK_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_we,
    input logic [BANK_W-1:0]            bus_wdata,
    input logic [BANK_W-1:0]            bus_rdata,
    input logic [NUM_GROUPS*LANE_W-1:0] irq_in,
    input logic [NUM_GROUPS-1:0]        grp_req,
    input logic [FLAT_W-1:0]            en_flat
);

    int       cur_bank;
    reg_sel_e cur_sel;
    logic     cur_ok;
    logic     pend_set, pend_clr;
    int       pend_bank;
    logic [BANK_W-1:0] pend_data;
    logic [BANK_W-1:0] pend_en;
    logic [FLAT_W-1:0] live;

    assign cur_bank = int'(bus_addr[ADDR_W-1:OFS_W]);
    assign cur_sel  = offset_to_sel(bus_addr[OFS_W-1:0]);
    assign cur_ok   = cur_bank < NUM_BANKS;
    assign live     = FLAT_W'(irq_in) & en_flat;
    assign pend_en  = BANK_W'(en_flat >> (pend_bank * BANK_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set  <= 1'b0;
            pend_clr  <= 1'b0;
            pend_bank <= 0;
            pend_data <= '0;
        end else begin
            pend_set  <= bus_we && cur_ok && (cur_sel == REG_EN_SET);
            pend_clr  <= bus_we && cur_ok && (cur_sel == REG_EN_CLR);
            pend_bank <= cur_bank;
            pend_data <= bus_wdata & lane_mask(cur_bank, NUM_GROUPS);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (grp_req == '0) && (en_flat == '0)); // R1

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        pend_set |-> ((pend_en & pend_data) == pend_data)); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        pend_clr |-> ((pend_en & pend_data) == '0)); // R3

    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |=> (grp_req == '0)); // R5

    AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!cur_ok || (cur_sel == REG_EN_CLR) || (cur_sel == REG_NONE)) |-> (bus_rdata == '0)); // R7

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (!cur_ok || (cur_sel == REG_STATUS) || (cur_sel == REG_NONE)))
        |=> $stable(en_flat)); // R8

endmodule

bind irq_group_combiner cmb_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .grp_req   (grp_req),
    .en_flat   (en_flat)
);

// File: tb/sim_irq_group_combiner.sv
`timescale 1ns/1ps
module sim_irq_group_combiner;

    localparam int NG  = 20;
    localparam int AW  = 12;
    localparam int NB  = (NG + 3) / 4;
    localparam int IW  = NG * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [IW-1:0] irq_in = '0;
    logic [NG-1:0] grp_req;

    int checks = 0;
    int failures = 0;
    logic [31:0] men [NB];
    logic [IW-1:0] irq_v;

    always #2.5 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .grp_req(grp_req)
    );

    function automatic logic [NG-1:0] req_of(input logic [IW-1:0] irq);
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++)
            r[g] = |(irq[g*8 +: 8] & men[g/4][(g%4)*8 +: 8]);
        return r;
    endfunction

    function automatic logic [31:0] rd_model(input logic [AW-1:0] a);
        int bk;
        logic [NB*32-1:0] ip;
        bk = int'(a[AW-1:4]);
        ip = (NB*32)'(irq_v);
        if (bk >= NB) return 32'h0;
        case (a[3:0])
            4'h0:    return men[bk];
            4'hC:    return ip[bk*32 +: 32] & men[bk];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clocked cycle: optional write plus new input levels; grp_req checked after the edge.
    task automatic step(input string req, input logic we, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [IW-1:0] irq);
        logic [NG-1:0] exp_req;
        int bk;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; irq_in = irq; irq_v = irq;
        exp_req = req_of(irq);
        bk = int'(a[AW-1:4]);
        if (we && bk < NB) begin
            if (a[3:0] == 4'h0) men[bk] = men[bk] | d;
            else if (a[3:0] == 4'h4) men[bk] = men[bk] & ~d;
        end
        @(posedge clk); #1;
        chk(req, 32'(grp_req), 32'(exp_req));
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, rd_model(a));
    endtask

    function automatic logic [AW-1:0] addr_of(input int bk, input logic [3:0] ofs);
        return AW'(bk * 16) | AW'(ofs);
    endfunction

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [IW-1:0] ones;
        void'($urandom(32'h1234_5678));
        for (int b = 0; b < NB; b++) men[b] = '0;
        irq_v = '0;
        ones = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 req after reset", 32'(grp_req), 32'h0);
        rd("R1 enable after reset", addr_of(0, 4'h0));
        rd("R1 enable bank 4 after reset", addr_of(4, 4'h0));

        // R2: set bits in bank 1 lanes 0 and 2 (groups 4 and 6)
        step("R2 set", 1'b1, addr_of(1, 4'h0), 32'h00A5_0081, '0);
        rd("R2 readback", addr_of(1, 4'h0));
        step("R2 set keeps others", 1'b1, addr_of(1, 4'h0), 32'h0000_0100, '0);
        rd("R2 readback merge", addr_of(1, 4'h0));

        // R4/R5: drive input 4*8+7 (group 4 bit 7, enabled)
        step("R5 latency", 1'b0, '0, '0, IW'(1) << 39);
        rd("R4 status lane", addr_of(1, 4'hC));
        // R6: hold level several cycles
        for (int i = 0; i < 4; i++) step("R6 hold", 1'b0, '0, '0, IW'(1) << 39);
        // R6: drop by disabling
        step("R6 clear drops", 1'b1, addr_of(1, 4'h4), 32'h0000_0080, IW'(1) << 39);
        step("R6 after clear", 1'b0, '0, '0, IW'(1) << 39);
        rd("R3 readback", addr_of(1, 4'h0));

        // R8: ignored writes
        step("R8 write status", 1'b1, addr_of(1, 4'hC), 32'hFFFF_FFFF, '0);
        step("R8 write unused", 1'b1, addr_of(2, 4'h8), 32'hFFFF_FFFF, '0);
        step("R8 write out of range", 1'b1, addr_of(NB, 4'h0), 32'hFFFF_FFFF, '0);
        rd("R8 bank 1 unchanged", addr_of(1, 4'h0));
        rd("R8 bank 2 unchanged", addr_of(2, 4'h0));

        // R7: dead reads
        step("R7 setup", 1'b1, addr_of(3, 4'h0), 32'hFFFF_FFFF, ones);
        rd("R7 clear offset", addr_of(3, 4'h4));
        rd("R7 offset 8", addr_of(3, 4'h8));
        rd("R7 odd offset", addr_of(3, 4'h1));
        rd("R7 out of range", addr_of(NB, 4'hC));
        rd("R4 full status", addr_of(3, 4'hC));
        step("R6 all enabled high", 1'b0, '0, '0, ones);
        step("R6 inputs drop", 1'b0, '0, '0, '0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int bk;
            logic [3:0] ofs;
            logic [IW-1:0] ir;
            bk = int'($urandom_range(0, NB + 2));
            case ($urandom_range(0, 4))
                0: ofs = 4'h0;
                1: ofs = 4'h4;
                2: ofs = 4'hC;
                3: ofs = 4'h8;
                default: ofs = 4'($urandom);
            endcase
            for (int w = 0; w < IW; w += 32) ir[w +: 32] = $urandom & $urandom;
            step("R5 random req", 1'($urandom), addr_of(bk, ofs), $urandom, ir);
            rd("R4 random read", addr_of(int'($urandom_range(0, NB + 1)),
                                          ($urandom_range(0, 1) == 0) ? 4'h0 : 4'hC));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule